// File: doc/BRIEF.md
# ECC First-Failure Capture Registers

This block sits next to the ECC decoder of a memory controller and keeps a record of the first error of each kind. A correctable error strobe carries the check bits of the failing word. An uncorrectable error strobe carries the failing access address. For each error class the block holds a sticky flag and one capture register. The first strobe of a class loads the register and locks it, so later strobes of that class leave it alone. Software releases the lock by writing a one to that class's flag. The next strobe of the class is then captured.

Software reaches the block through a simple single-cycle register port. A read returns data combinationally in the same cycle. A write takes effect at the next rising clock edge.

The failing address is up to 64 bits wide and is read as two 32-bit words. When the address is 32 bits or narrower, the upper word reads zero.

The check-bit width follows the data-path width: 8 bits for a 72-bit path and 16 bits for a 144-bit path. The unused upper bits of that register read zero.

Top module: `ecc_first_fail_log`

## Requirements
- R1: After reset every register reads zero, and capture is armed for both error classes.
- R2: A correctable strobe sets the status flag at bit 0 (offset 0x0), and an uncorrectable strobe sets the flag at bit 1. Each flag stays set until it is cleared.
- R3: Writing offset 0x0 clears a flag wherever the write data holds a 1 at that flag's bit. A 0 in that bit leaves the flag unchanged.
- R4: The address word at offset 0x8 (address bits 31:0) and the word at offset 0xC (address bits 63:32) hold the address of the first uncorrectable error. Later uncorrectable strobes do not change them while bit 1 of the status register is set.
- R5: The check-bit register at offset 0x4 holds the check bits of the first correctable error. Later correctable strobes do not change it while bit 0 of the status register is set.
- R6: Clearing a flag re-arms its capture, so the next strobe of that class is stored.
- R7: When a strobe arrives in the same cycle as a write that clears its flag, the new data is captured and the flag remains set.
- R8: A correctable and an uncorrectable strobe in the same cycle are both captured, each into its own register.
- R9: Offset 0xC returns the address bits above bit 31, zero-extended. It reads zero when the address width is 32 or less.
- R10: The check-bit register is DQ_W/9 bits wide (8 bits by default), and its upper bits read zero.
- R11: Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return zero. Writes to offsets 0x4, 0x8 and 0xC change nothing. The read data is zero whenever the cycle is not a read (reg_en low or reg_we high).

Ports (parameter defaults: DQ_W = 72, ADDR_W = 40, REG_AW = 4):

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_strobe | input | 1 | Correctable error seen on this access |
| ue_strobe | input | 1 | Uncorrectable error seen on this access |
| err_addr | input | ADDR_W | Address of the access being reported |
| err_ecc | input | DQ_W/9 | Check bits of the access being reported |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | REG_AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle |

## Verification
The stimulus begins with isolated strobes of each class. These show that the first strobe is captured and that repeated strobes are blocked by the lock.

Status writes then use a 0-bit write, a write to a single flag and a write to both flags. Together these separate a write-one clear from a plain write, and show that clearing one class does not re-arm the other. Writes to the capture registers are also included, to confirm they have no effect.

A strobe issued in the same cycle as its own clear shows whether the new error takes priority. A cycle carrying both strobes shows that the two classes are handled independently.

Addresses are chosen with distinct upper bits, so that the zero extension of the high word can be checked. Misaligned and out-of-map offsets are read to confirm they return zero.

// File: rtl/ecc_log_pkg.sv
// Package: shared constants and helpers for the ECC first-failure logger.
// Assumes a 32-bit register data path and byte offsets on the register port.
package ecc_log_pkg;

    localparam int unsigned WORD_W = 32;

    // Register byte offsets; software depends on these values.
    localparam logic [3:0] OFF_STATUS  = 4'h0;
    localparam logic [3:0] OFF_CE_ECC  = 4'h4;
    localparam logic [3:0] OFF_UE_LO   = 4'h8;
    localparam logic [3:0] OFF_UE_HI   = 4'hC;

    // Bit positions of the flags in the status word.
    localparam int unsigned CE_BIT = 0;
    localparam int unsigned UE_BIT = 1;

    // Check bits per data word: 8 per 64 data bits, i.e. DQ/9.
    function automatic int unsigned ecc_width(input int unsigned dq);
        return dq / 9;
    endfunction

endpackage

// File: rtl/ecc_log_capture.sv
// Module: one-shot capture unit for a single error class.
// Holds a sticky flag and a data register. Data is loaded when a strobe
// arrives while the flag is clear, or in the same cycle as a clear request,
// in which case the new error wins. Assumes the clear request is a
// single-cycle pulse from the register decoder.
module ecc_log_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic         clear_req,
    input  logic [W-1:0] data_in,
    output logic         flag,
    output logic [W-1:0] data_q
);

    logic load;

    // Capture is armed when the flag is clear or being cleared right now.
    always_comb begin
        load = strobe && (!flag || clear_req);
    end

    // Sticky flag: a strobe sets it, a clear drops it, and a strobe beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (strobe) begin
            flag <= 1'b1;
        end else if (clear_req) begin
            flag <= 1'b0;
        end
    end

    // Data register: loaded only on an armed strobe, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/ecc_log_bus.sv
// Module: register port decoder and read multiplexer.
// Turns write-one-to-clear writes to the status word into clear pulses and
// selects read data by byte offset. Reads are combinational, and unmapped
// offsets return zero. Assumes every input word is already zero-padded.
module ecc_log_bus
    import ecc_log_pkg::*;
#(
    parameter int unsigned REG_AW = 4
) (
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              ce_flag,
    input  logic              ue_flag,
    input  logic [WORD_W-1:0] ce_word,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    output logic              ce_clear,
    output logic              ue_clear,
    output logic [WORD_W-1:0] reg_rdata
);

    logic              wr_status;
    logic              rd_cycle;
    logic [WORD_W-1:0] unused_wdata_bits;

    assign unused_wdata_bits = reg_wdata;

    // Decode a write to the status word and pick out the one-bits.
    always_comb begin
        wr_status = reg_en && reg_we && (reg_addr == REG_AW'(OFF_STATUS));
        ce_clear  = wr_status && reg_wdata[CE_BIT];
        ue_clear  = wr_status && reg_wdata[UE_BIT];
    end

    // Read multiplexer by exact byte offset; anything else reads zero.
    always_comb begin
        rd_cycle  = reg_en && !reg_we;
        reg_rdata = '0;
        if (rd_cycle) begin
            if (reg_addr == REG_AW'(OFF_STATUS)) begin
                reg_rdata[CE_BIT] = ce_flag;
                reg_rdata[UE_BIT] = ue_flag;
            end else if (reg_addr == REG_AW'(OFF_CE_ECC)) begin
                reg_rdata = ce_word;
            end else if (reg_addr == REG_AW'(OFF_UE_LO)) begin
                reg_rdata = lo_word;
            end else if (reg_addr == REG_AW'(OFF_UE_HI)) begin
                reg_rdata = hi_word;
            end
        end
    end

endmodule

// File: rtl/ecc_first_fail_log.sv
// Module: ECC first-failure logger, top level.
// Combines one capture unit for correctable errors (check bits) and one for
// uncorrectable errors (address) with the register decoder. Assumes
// ADDR_W <= 64 and that the check-bit width fits in 32 bits.
module ecc_first_fail_log
    import ecc_log_pkg::*;
#(
    parameter int unsigned DQ_W   = 72,
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned REG_AW = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ce_strobe,
    input  logic                          ue_strobe,
    input  logic [ADDR_W-1:0]             err_addr,
    input  logic [ecc_width(DQ_W)-1:0]    err_ecc,
    input  logic                          reg_en,
    input  logic                          reg_we,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata
);

    localparam int unsigned ECC_W = ecc_width(DQ_W);

    logic              ce_flag;
    logic              ue_flag;
    logic              ce_clear;
    logic              ue_clear;
    logic [ECC_W-1:0]  ecc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] ce_word;
    logic [WORD_W-1:0] lo_word;
    logic [WORD_W-1:0] hi_word;

    ecc_log_capture #(.W(ECC_W)) u_ce_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (ce_strobe),
        .clear_req (ce_clear),
        .data_in   (err_ecc),
        .flag      (ce_flag),
        .data_q    (ecc_q)
    );

    ecc_log_capture #(.W(ADDR_W)) u_ue_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (ue_strobe),
        .clear_req (ue_clear),
        .data_in   (err_addr),
        .flag      (ue_flag),
        .data_q    (addr_q)
    );

    // Zero-pad the check bits up to a register word.
    assign ce_word = WORD_W'(ecc_q);

    // Split the address into two words; the upper word exists only for wide addresses.
    generate
        if (ADDR_W > WORD_W) begin : g_wide_addr
            assign lo_word = addr_q[WORD_W-1:0];
            assign hi_word = WORD_W'(addr_q[ADDR_W-1:WORD_W]);
        end else begin : g_narrow_addr
            assign lo_word = WORD_W'(addr_q);
            assign hi_word = '0;
        end
    endgenerate

    ecc_log_bus #(.REG_AW(REG_AW)) u_bus (
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ce_flag   (ce_flag),
        .ue_flag   (ue_flag),
        .ce_word   (ce_word),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .ce_clear  (ce_clear),
        .ue_clear  (ue_clear),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/ecc_first_fail_log_chk.sv
// Module: assertion checker for the ECC first-failure logger, bound to the top.
// Relates the strobes and register writes at the ports to the held state.
module ecc_first_fail_log_chk #(
    parameter int unsigned ECC_W  = 8,
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_strobe,
    input logic              ue_strobe,
    input logic [ADDR_W-1:0] err_addr,
    input logic [ECC_W-1:0]  err_ecc,
    input logic              reg_en,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              ce_flag,
    input logic              ue_flag,
    input logic [ECC_W-1:0]  ecc_q,
    input logic [ADDR_W-1:0] addr_q
);

    logic wr0;
    assign wr0 = reg_en && reg_we && (reg_addr == '0);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (!ce_flag && !ue_flag && addr_q == '0 && ecc_q == '0)); // R1

    AST_STROBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_strobe || ce_strobe) |=> ((ue_flag || !$past(ue_strobe)) && (ce_flag || !$past(ce_strobe)))); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_flag && !(wr0 && reg_wdata[1])) |=> ue_flag); // R3

    AST_UE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_flag && !(wr0 && reg_wdata[1])) |=> $stable(addr_q)); // R4

    AST_CE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_flag && !(wr0 && reg_wdata[0])) |=> $stable(ecc_q)); // R5

    AST_REARM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_strobe && (!ue_flag || (wr0 && reg_wdata[1]))) |=> (addr_q == $past(err_addr))); // R6

    AST_STROBE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_strobe && wr0 && reg_wdata[0]) |=> (ce_flag && ecc_q == $past(err_ecc))); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !reg_we && reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0)); // R11

endmodule

bind ecc_first_fail_log ecc_first_fail_log_chk #(
    .ECC_W  (ECC_W),
    .ADDR_W (ADDR_W),
    .REG_AW (REG_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_strobe (ce_strobe),
    .ue_strobe (ue_strobe),
    .err_addr  (err_addr),
    .err_ecc   (err_ecc),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ce_flag   (ce_flag),
    .ue_flag   (ue_flag),
    .ecc_q     (ecc_q),
    .addr_q    (addr_q)
);

// File: tb/ecc_first_fail_log_bench.sv
// Bench: behavioural reference model compared against the read port every cycle.
module ecc_first_fail_log_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 40;
    localparam int ECC_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_strobe = 1'b0;
    logic              ue_strobe = 1'b0;
    logic [ADDR_W-1:0] err_addr = '0;
    logic [ECC_W-1:0]  err_ecc = '0;
    logic              reg_en = 1'b0;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference state
    bit                m_ce, m_ue;
    logic [ECC_W-1:0]  m_ecc;
    logic [ADDR_W-1:0] m_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_first_fail_log u_ecc_first_fail_log (
        .clk(clk), .rst_n(rst_n), .ce_strobe(ce_strobe), .ue_strobe(ue_strobe),
        .err_addr(err_addr), .err_ecc(err_ecc), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] expect_read();
        logic [63:0] a;
        a = 64'(m_addr);
        if (!reg_en || reg_we) return 32'h0;
        case (reg_addr)
            4'h0: return {30'h0, m_ue, m_ce};
            4'h4: return 32'(m_ecc);
            4'h8: return a[31:0];
            4'hC: return a[63:32];
            default: return 32'h0;
        endcase
    endfunction

    // One clock: drive, compare the read port, then advance the model at the edge.
    task automatic cyc(input bit ce, input bit ue, input logic [ADDR_W-1:0] a,
                       input logic [ECC_W-1:0] e, input bit en, input bit we,
                       input logic [3:0] off, input logic [31:0] wd, input string tag);
        bit clr_ce, clr_ue;
        logic [31:0] exp_v;
        @(negedge clk);
        ce_strobe = ce; ue_strobe = ue; err_addr = a; err_ecc = e;
        reg_en = en; reg_we = we; reg_addr = off; reg_wdata = wd;
        #2;
        exp_v = expect_read();
        compared++;
        if (reg_rdata !== exp_v) begin
            mismatched++;
            $display("FAIL %s off=%h actual=%h expected=%h", tag, off, reg_rdata, exp_v);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_ce = 0; m_ue = 0; m_ecc = '0; m_addr = '0;
        end else begin
            clr_ce = en && we && off == 4'h0 && wd[0];
            clr_ue = en && we && off == 4'h0 && wd[1];
            if (ce && (!m_ce || clr_ce)) m_ecc = e;
            if (ue && (!m_ue || clr_ue)) m_addr = a;
            m_ce = ce || (m_ce && !clr_ce);
            m_ue = ue || (m_ue && !clr_ue);
        end
    endtask

    task automatic rd(input logic [3:0] off, input string tag);
        cyc(0, 0, '0, '0, 1, 0, off, '0, tag);
    endtask

    task automatic wr(input logic [3:0] off, input logic [31:0] wd, input string tag);
        cyc(0, 0, '0, '0, 1, 1, off, wd, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        m_ce = 0; m_ue = 0; m_ecc = '0; m_addr = '0;
        rst_n = 0;
        repeat (3) rd(4'h0, "R1");
        @(negedge clk); rst_n = 1;
        // R1: all registers zero after reset
        rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");
        // R2 R4 R9: first uncorrectable error captured, high word zero-extended
        cyc(0, 1, 40'hAB_1234_5678, '0, 1, 0, 4'h0, '0, "R2");
        rd(4'h0, "R2"); rd(4'h8, "R4"); rd(4'hC, "R9");
        // R4: later uncorrectable strobes are blocked
        cyc(0, 1, 40'h5C_DEAD_BEEF, '0, 0, 0, 4'h0, '0, "R4");
        rd(4'h8, "R4"); rd(4'hC, "R4");
        // R3: a 0 bit leaves flags alone; R11: writes to capture regs ignored
        wr(4'h0, 32'h0, "R3"); rd(4'h0, "R3");
        wr(4'h8, 32'hFFFF_FFFF, "R11"); wr(4'hC, 32'hFFFF_FFFF, "R11");
        rd(4'h8, "R11"); rd(4'hC, "R11");
        // R3 R6: clear the uncorrectable flag, then re-capture
        wr(4'h0, 32'h2, "R3"); rd(4'h0, "R3");
        cyc(0, 1, 40'h01_0000_0010, '0, 0, 0, 4'h0, '0, "R6");
        rd(4'h8, "R6"); rd(4'hC, "R6");
        // R5 R10: first correctable check bits captured and locked
        cyc(1, 0, '0, 8'h5A, 0, 0, 4'h0, '0, "R5");
        cyc(1, 0, '0, 8'h33, 0, 0, 4'h0, '0, "R5");
        wr(4'h4, 32'hFFFF_FFFF, "R11");
        rd(4'h4, "R10"); rd(4'h0, "R2");
        // R3: clearing one flag keeps the other
        wr(4'h0, 32'h1, "R3"); rd(4'h0, "R3"); rd(4'h8, "R3");
        cyc(1, 0, '0, 8'h11, 0, 0, 4'h0, '0, "R6");
        // R7: strobe in the same cycle as its own clear wins
        cyc(1, 0, '0, 8'h77, 1, 1, 4'h0, 32'h1, "R7");
        rd(4'h0, "R7"); rd(4'h4, "R7");
        // R8: both classes in one cycle after clearing both
        wr(4'h0, 32'h3, "R8"); rd(4'h0, "R8");
        cyc(1, 1, 40'hFE_8765_4321, 8'hC3, 0, 0, 4'h0, '0, "R8");
        rd(4'h0, "R8"); rd(4'h4, "R8"); rd(4'h8, "R8"); rd(4'hC, "R9");
        // R11: misaligned and unmapped offsets, and non-read cycles, return zero
        rd(4'h1, "R11"); rd(4'h2, "R11"); rd(4'h5, "R11"); rd(4'hD, "R11"); rd(4'hF, "R11");
        wr(4'h4, 32'h0, "R11");
        cyc(0, 0, '0, '0, 0, 0, 4'h8, '0, "R11");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule